// File: doc/BRIEF.md
# Byte-Strobed Configuration Register Bridge

This block receives configuration traffic from a host over a single 8-bit location. The host presents a byte with its top bit low, then presents the same byte with the top bit high. The rising edge of that top bit, taken through a two-flop synchroniser, loads the byte into the block. Bit 6 of an accepted byte selects its meaning. When bit 6 is set, bits 5:0 name one of 64 internal 6-bit registers. When bit 6 is clear, bits 5:0 are stored in the register that was named last. The contents of the named register are always visible on a 7-bit read bus.

Registers 0 to 3 form a window for programming a crossbar routing table. Registers 0 and 1 hold the upper and lower halves of a 12-bit destination index. Registers 2 and 3 hold the upper and lower halves of a 12-bit source index. A value write to register 3 commits the assembled source into the table entry of the assembled destination. Each destination holds exactly one source. A single source may be stored in any number of destinations. The datapath reads the table through a combinational lookup port.

Top module: `cfg_route_bridge`

## Requirements
- R1: A byte is accepted only when bit 7 of `host_byte_i` goes from 0 to 1. Changing bits 6:0 while bit 7 stays high accepts nothing, and a falling bit 7 accepts nothing.
- R2: An accepted byte with bit 6 = 1 loads bits 5:0 into the select pointer and changes no register or table entry.
- R3: An accepted byte with bit 6 = 0 writes bits 5:0 into the selected register and leaves the select pointer unchanged, so consecutive value bytes overwrite the same register.
- R4: `rd_data_o` bits 5:0 always equal the selected register, and bit 6 always reads 0.
- R5: A value write to register 3 stores source {reg2, new value} (reg2 in bits 11:6) at destination {reg0, reg1} (reg0 in bits 11:6). Writes to registers 0 to 2 alone leave the table unchanged.
- R6: A commit whose destination is NUM_DST or above leaves every table entry unchanged.
- R7: Each destination holds only the source of its latest commit. One source may be stored in several destinations at the same time.
- R8: After reset, all registers, the select pointer and all table entries are 0.
- R9: The effect of an accepted byte is visible on the outputs after the second rising clock edge that follows the first edge at which bit 7 is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_byte_i | input | 8 | Host byte. Bit 7 is the strobe, bit 6 is the select flag, bits 5:0 are the payload |
| rd_data_o | output | 7 | Selected register, zero-extended |
| route_dst_i | input | $clog2(NUM_DST) (4) | Table lookup destination |
| route_src_o | output | 12 | Source stored for `route_dst_i` |

## Verification
The checker runs on every cycle. It checks that two consecutive cycles never both accept a byte, that a select byte loads the pointer, that a value byte keeps the pointer and reads back at once, that bit 6 of the read bus stays 0, that a commit occurs only on a value write to register 3, and that no out-of-range destination is written. The bench scenarios cover the properties that depend on a history of bytes. These are the exact latency from the strobe edge, the rejection of level changes while bit 7 is held high, the assembly of a 12-bit route from four separate writes, the overwrite of one destination, the fan-out of one source, and the dropping of out-of-range commits. To check them, the bench compares a behavioural model against the read bus and against every table entry.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  localparam int HALF_W   = 6;
  localparam int BYTE_W   = HALF_W + 2;
  localparam int NUM_REGS = 1 << HALF_W;
  localparam int IDX_W    = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;

  // low 7 bits of an accepted byte
  typedef struct packed {
    logic  is_sel;
    half_t val;
  } cmd_t;

  localparam half_t REG_DST_HI = half_t'(0);
  localparam half_t REG_DST_LO = half_t'(1);
  localparam half_t REG_SRC_HI = half_t'(2);
  localparam half_t REG_SRC_LO = half_t'(3);
endpackage

// File: rtl/cfg_strobe_sync.sv
module cfg_strobe_sync
  import cfg_route_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              acc_o,
  output cmd_t              cmd_o
);
  logic [BYTE_W-1:0] stg_q [STAGES];
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= byte_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stg_q[STAGES-1][BYTE_W-1];
  end

  assign acc_o = stg_q[STAGES-1][BYTE_W-1] & ~prev_q;
  assign cmd_o = cmd_t'(stg_q[STAGES-1][BYTE_W-2:0]);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_route_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  cmd_t             cmd_i,
  output half_t            sel_o,
  output half_t            rd_o,
  output logic             commit_o,
  output logic [IDX_W-1:0] commit_dst_o,
  output logic [IDX_W-1:0] commit_src_o
);
  half_t sel_q;
  half_t regs_q [NUM_REGS];
  logic  wr_val;

  assign wr_val = acc_i & ~cmd_i.is_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   sel_q <= '0;
    else if (acc_i && cmd_i.is_sel) sel_q <= cmd_i.val;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[i] <= '0;
      else if (wr_val && (sel_q == half_t'(i)))  regs_q[i] <= cmd_i.val;
    end
  end

  assign sel_o        = sel_q;
  assign rd_o         = regs_q[sel_q];
  // source low half comes straight from the byte so commit needs no extra cycle
  assign commit_o     = wr_val && (sel_q == REG_SRC_LO);
  assign commit_dst_o = {regs_q[REG_DST_HI], regs_q[REG_DST_LO]};
  assign commit_src_o = {regs_q[REG_SRC_HI], cmd_i.val};
endmodule

// File: rtl/cfg_route_table.sv
module cfg_route_table
  import cfg_route_pkg::*;
#(
  parameter int NUM_DST = 16,
  localparam int AW     = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [IDX_W-1:0] src_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [IDX_W-1:0] rd_src_o,
  output logic             wr_hit_o
);
  logic [IDX_W-1:0] ent_q [NUM_DST];
  logic             in_range;

  assign in_range = {{(32-IDX_W){1'b0}}, dst_i} < 32'(NUM_DST);
  assign wr_hit_o = we_i & in_range;

  for (genvar d = 0; d < NUM_DST; d++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       ent_q[d] <= '0;
      else if (wr_hit_o && (dst_i[AW-1:0] == AW'(d)))     ent_q[d] <= src_i;
    end
  end

  assign rd_src_o = ent_q[rd_addr_i];
endmodule

// File: rtl/cfg_route_bridge.sv
module cfg_route_bridge
  import cfg_route_pkg::*;
#(
  parameter int NUM_DST  = 16,
  parameter int SYNC_LEN = 2,
  localparam int DST_AW  = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] host_byte_i,
  output logic [BYTE_W-2:0] rd_data_o,
  input  logic [DST_AW-1:0] route_dst_i,
  output logic [IDX_W-1:0]  route_src_o
);
  logic             acc;
  cmd_t             cmd;
  half_t            sel_idx;
  half_t            rd_half;
  logic             commit;
  logic [IDX_W-1:0] commit_dst;
  logic [IDX_W-1:0] commit_src;
  logic             tbl_we;

  cfg_strobe_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .byte_i (host_byte_i),
    .acc_o  (acc),
    .cmd_o  (cmd)
  );

  cfg_regfile u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_i        (acc),
    .cmd_i        (cmd),
    .sel_o        (sel_idx),
    .rd_o         (rd_half),
    .commit_o     (commit),
    .commit_dst_o (commit_dst),
    .commit_src_o (commit_src)
  );

  cfg_route_table #(.NUM_DST(NUM_DST)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (commit),
    .dst_i     (commit_dst),
    .src_i     (commit_src),
    .rd_addr_i (route_dst_i),
    .rd_src_o  (route_src_o),
    .wr_hit_o  (tbl_we)
  );

  assign rd_data_o = {1'b0, rd_half};
endmodule

// File: rtl/cfg_route_bridge_chk.sv
module cfg_route_bridge_chk
  import cfg_route_pkg::*;
#(
  parameter int NUM_DST = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_i,
  input logic [BYTE_W-2:0] cmd_i,
  input logic [HALF_W-1:0] sel_i,
  input logic [BYTE_W-2:0] rd_data_i,
  input logic              commit_i,
  input logic              tbl_we_i,
  input logic [IDX_W-1:0]  commit_dst_i
);
  a_r1_single_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> !acc_i);

  a_r2_select_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && cmd_i[HALF_W]) |=> (sel_i == $past(cmd_i[HALF_W-1:0])));

  a_r3_value_keeps_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !cmd_i[HALF_W]) |=> $stable(sel_i));

  a_r3_value_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !cmd_i[HALF_W]) |=> (rd_data_i[HALF_W-1:0] == $past(cmd_i[HALF_W-1:0])));

  a_r2_idle_sel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(sel_i));

  a_r4_top_bit_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i[HALF_W] == 1'b0);

  a_r5_commit_reg3_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (acc_i && !cmd_i[HALF_W] && sel_i == HALF_W'(3)));

  a_r6_no_oob_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_i |-> ({{(32-IDX_W){1'b0}}, commit_dst_i} < 32'(NUM_DST)));
endmodule

bind cfg_route_bridge cfg_route_bridge_chk #(.NUM_DST(NUM_DST)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_i        (acc),
  .cmd_i        (cmd),
  .sel_i        (sel_idx),
  .rd_data_i    (rd_data_o),
  .commit_i     (commit),
  .tbl_we_i     (tbl_we),
  .commit_dst_i (commit_dst)
);

// File: tb/cfg_route_bridge_test.sv
module cfg_route_bridge_test;
  localparam int NUM_DST = 16;
  localparam int AW      = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    host_byte = 8'h00;
  logic [6:0]    rd_data;
  logic [AW-1:0] route_dst = '0;
  logic [11:0]   route_src;

  int    vectors = 0;
  int    errors  = 0;
  int    cyc     = 0;
  string cur_req = "R8";

  int mreg [64];
  int msel;
  int mtab [NUM_DST];
  int q_byte [$];
  int q_due  [$];
  bit prev_b7;

  always #10 clk = ~clk;

  cfg_route_bridge #(.NUM_DST(NUM_DST)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .host_byte_i (host_byte),
    .rd_data_o   (rd_data),
    .route_dst_i (route_dst),
    .route_src_o (route_src)
  );

  task automatic model_apply(int b);
    int v = b & 8'h3f;
    if (b & 8'h40) msel = v;
    else begin
      mreg[msel] = v;
      if (msel == 3) begin
        int d = (mreg[0] << 6) | mreg[1];
        if (d < NUM_DST) mtab[d] = (mreg[2] << 6) | v;
      end
    end
  endtask

  // R9: byte seen with fresh bit 7 at edge t takes effect at edge t+2
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mreg[i]) mreg[i] = 0;
      foreach (mtab[i]) mtab[i] = 0;
      msel = 0; prev_b7 = 0;
      q_byte.delete(); q_due.delete();
    end else begin
      cyc++;
      while (q_due.size() > 0 && q_due[0] == cyc) begin
        model_apply(q_byte.pop_front());
        void'(q_due.pop_front());
      end
      if (host_byte[7] && !prev_b7) begin
        q_byte.push_back(int'(host_byte));
        q_due.push_back(cyc + 2);
      end
      prev_b7 = host_byte[7];
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (rd_data !== 7'(mreg[msel])) begin
      errors++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", cur_req, rd_data, mreg[msel]);
    end
    vectors++;
    if (route_src !== 12'(mtab[route_dst])) begin
      errors++;
      $display("FAIL %s route[%0d] actual=%03h expected=%03h", cur_req, route_dst,
               route_src, mtab[route_dst]);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
    end
  endtask

  task automatic send(logic [6:0] b);
    host_byte = {1'b0, b}; step(3);
    host_byte = {1'b1, b}; step(4);
  endtask

  task automatic wr_reg(int r, int v);
    send(7'(8'h40 | r));
    send(7'(v));
  endtask

  task automatic route(int dst, int src);
    wr_reg(0, (dst >> 6) & 63);
    wr_reg(1, dst & 63);
    wr_reg(2, (src >> 6) & 63);
    wr_reg(3, src & 63);
  endtask

  task automatic sweep_table();
    for (int d = 0; d < NUM_DST; d++) begin
      route_dst = AW'(d); step(1);
    end
  endtask

  task automatic check_sel(string req, int r, int exp);
    send(7'(8'h40 | r)); step(1);
    vectors++;
    if (rd_data !== 7'(exp)) begin
      errors++;
      $display("FAIL %s reg%0d actual=%02h expected=%02h", req, r, rd_data, exp);
    end
  endtask

  initial begin
    fork
      begin
        step(150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    join_none

    cur_req = "R8";
    step(3); rst_n = 1'b1; step(2);
    sweep_table();
    check_sel("R8", 40, 0);

    cur_req = "R2";
    send(7'h45); step(2);
    check_sel("R2", 5, 0);

    cur_req = "R3";
    send(7'h2a);
    send(7'h15);
    check_sel("R3", 5, 8'h15);

    cur_req = "R4";
    wr_reg(9, 8'h3f);
    check_sel("R4", 9, 8'h3f);
    check_sel("R4", 5, 8'h15);

    cur_req = "R1";
    host_byte = 8'h80 | 8'h22; step(6);
    host_byte = 8'h80 | 8'h4a; step(6);
    host_byte = 8'h11; step(6);
    check_sel("R1", 5, 8'h15);
    check_sel("R1", 10, 0);

    cur_req = "R9";
    send(7'h47);
    host_byte = 8'h0c; step(3);
    host_byte = 8'h8c; step(1);
    host_byte = 8'h8c; step(4);
    check_sel("R9", 7, 8'h0c);

    cur_req = "R5";
    wr_reg(0, 0); wr_reg(1, 5); wr_reg(2, 8'h12);
    sweep_table();
    wr_reg(3, 8'h34);
    sweep_table();
    route_dst = AW'(5); step(1);
    vectors++;
    if (route_src !== 12'h4b4) begin
      errors++;
      $display("FAIL R5 route[5] actual=%03h expected=4b4", route_src);
    end
    wr_reg(2, 8'h3f);
    sweep_table();

    cur_req = "R7";
    route(7, 12'h4b4);
    route(12, 12'h4b4);
    route(5, 12'hfff);
    route(0, 12'h001);
    route(15, 12'h800);
    sweep_table();

    cur_req = "R6";
    route(64, 12'h555);
    route(20, 12'h2aa);
    route(4095, 12'h123);
    sweep_table();
    check_sel("R6", 0, 8'h3f);

    cur_req = "R8";
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(2);
    sweep_table();
    check_sel("R8", 3, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule